// File: doc/BRIEF.md
# Three-Bus Microsequenced Accumulator Datapath

This block is a small accumulator datapath built around three internal buses. Two read ports of a register file drive the A and B buses and feed an ALU with a shifter. The ALU output is held in a result register, and the C bus then carries it back to a destination entry. The program counter, accumulator, instruction register and the two memory-side registers (address and buffer) all live in the same register file. One entry of that file is hardwired to the value one, and writes aimed at it are lost. A hardwired sequencer runs every instruction as a fixed series of bus steps. Most steps take two clocks: one clock computes and latches, the next writes back. Memory is outside the block and answers a read one clock after the request.

An instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit operand address in bits 11:0. Opcode 0x2 performs the add but sends the result to the constant-one entry, so only the condition codes change. Opcode 0x3 adds and then shifts the sum right by one. Every other opcode adds the memory operand into the accumulator. The PC increment is placed in the memory wait of the instruction fetch, which costs no extra clocks because the increment does not depend on the fetched word.

Top module: `cpu3b_core`

## Requirements
- R1: Register-file entry 5 always reads as 0x0001. A C-bus write that names entry 5 changes no register, so later PC increments still add exactly one.
- R2: With opcode 0x2 in IR[15:12], the execute step updates Z, N and C from accumulator plus operand, and the accumulator keeps its previous value.
- R3: The PC advances by exactly one (mod 2^16) once per instruction. The ALU forms it from the PC on the A bus and the constant-one entry on the B bus, and the PC is written at the end of step 3.
- R4: `step` runs 0,1,...,11 and then wraps to 0, so every instruction takes 12 clocks. Steps 0, 2, 4, 6 and 10 compute into the result register. Steps 1, 3, 5, 7 and 11 write back.
- R5: Fetch: step 0 copies the PC toward the address register. `mem_rd` is high in step 2 with `mem_addr` equal to PC[11:0]. The buffer captures `mem_rdata` at the end of step 3, and IR holds that word from step 6 on.
- R6: Operand fetch: step 6 passes only IR[11:0] (upper four bits zero) into the address register. `mem_rd` is high in step 8 with `mem_addr` = IR[11:0], and the buffer captures the data at the end of step 9.
- R7: Any opcode other than 0x2 and 0x3 sets the accumulator to accumulator plus operand, modulo 2^16.
- R8: Opcode 0x3 sets the accumulator to (accumulator + operand) mod 2^16 shifted right by one with a zero fill. C is the carry out of the add.
- R9: Each compute step sets Z (result zero), N (result bit 15) and C. C is the adder carry for add steps and 0 for pass steps. Write-back and memory steps leave the flags unchanged.
- R10: `instr_done` is high for exactly one clock, in the step-0 cycle after each instruction ends. At that point the accumulator and flags already show the instruction's effect.
- R11: During reset, `step`, PC, accumulator, IR, flags, `instr_done` and `mem_rd` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address, low bits of the address register |
| mem_rd | output | 1 | Read request; data expected on `mem_rdata` next clock |
| mem_rdata | input | 16 | Read data from external memory |
| instr_done | output | 1 | One-clock pulse after each instruction completes |
| step | output | 4 | Current sequencer step, 0 to 11 |
| pc_out | output | 16 | Program counter entry |
| acc_out | output | 16 | Accumulator entry |
| ir_out | output | 16 | Instruction register entry |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |

## Verification
The program exercises these corner cases:
- An add that wraps to exactly zero with carry, and an opcode-0x3 add whose carry is set while the shifted result is tiny. A design that takes the flags from the wrong stage, or shifts before adding, shows wrong Z, C or accumulator values.
- Two flags-only instructions sit between ordinary adds. A design that lets the constant-one entry be overwritten then breaks every later PC increment. A design that writes the result to the accumulator shows a changed accumulator.
- An operand at the top address 0xFFF catches an address path that lets opcode bits leak into the address register.

A behavioural model also compares the step count and the memory-request timing on every clock. That comparison exposes any off-by-one in when the buffer captures memory data.

// File: rtl/cpu3b_pkg.sv
package cpu3b_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 4;
    localparam int NREG   = 8;
    localparam int SEL_W  = $clog2(NREG);
    localparam int STEP_W = 4;

    // opcode values decoded from IR[15:12]
    localparam logic [OPC_W-1:0] OPC_FLAGS_ONLY = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADD_SHR    = 4'h3;

    typedef enum logic [SEL_W-1:0] {
        RS_PC  = 3'd0,
        RS_ACC = 3'd1,
        RS_IR  = 3'd2,
        RS_MAR = 3'd3,
        RS_MBR = 3'd4,
        RS_ONE = 3'd5,
        RS_G0  = 3'd6,
        RS_G1  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        AOP_PASS = 2'd0,
        AOP_ADD  = 2'd1,
        AOP_ADDR = 2'd2,
        AOP_AND  = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_LEFT  = 2'd2
    } shift_e;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH_A = 4'd0,
        ST_FETCH_W = 4'd1,
        ST_INC_A   = 4'd2,
        ST_INC_W   = 4'd3,
        ST_IR_A    = 4'd4,
        ST_IR_W    = 4'd5,
        ST_OPA_A   = 4'd6,
        ST_OPA_W   = 4'd7,
        ST_RD2     = 4'd8,
        ST_LD2     = 4'd9,
        ST_EX_A    = 4'd10,
        ST_EX_W    = 4'd11
    } step_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } flags_t;

    // one control word per sequencer step
    typedef struct packed {
        reg_sel_e src_a;
        reg_sel_e src_b;
        logic     use_b;
        alu_op_e  op;
        shift_e   sh;
        logic     exec;
        logic     wb;
        reg_sel_e dst;
        logic     mem_rd;
        logic     mbr_ld;
    } uop_t;

endpackage

// File: rtl/cpu3b_regfile.sv
module cpu3b_regfile
    import cpu3b_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int N       = NREG,
    parameter int ONE_IDX = int'(RS_ONE),
    parameter int MBR_IDX = int'(RS_MBR),
    localparam int IW     = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IW-1:0]      ra_idx,
    input  logic [IW-1:0]      rb_idx,
    output logic [DW-1:0]      ra_data,
    output logic [DW-1:0]      rb_data,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic               mbr_ld,
    input  logic [DW-1:0]      mbr_din,
    output logic [N-1:0][DW-1:0] view
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        if (i == ONE_IDX) begin : g_const
            // hardwired entry: no storage, C-bus writes find no target
            assign view[i] = DW'(1);
        end else begin : g_reg
            logic [DW-1:0] ent_d, ent_q;

            always_comb begin
                ent_d = ent_q;
                if (wr_en && (wr_idx == IW'(i))) begin
                    ent_d = wr_data;
                end
                if ((i == MBR_IDX) && mbr_ld) begin
                    ent_d = mbr_din;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else begin
                    ent_q <= ent_d;
                end
            end

            assign view[i] = ent_q;
        end
    end

    assign ra_data = view[ra_idx];
    assign rb_data = view[rb_idx];

endmodule

// File: rtl/cpu3b_alu.sv
module cpu3b_alu
    import cpu3b_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    input  shift_e        sh,
    output logic [DW-1:0] res,
    output flags_t        fl
);

    localparam logic [DW-1:0] ADDR_MASK = DW'((1 << AW) - 1);

    logic [DW:0]   wide_sum;
    logic [DW-1:0] pre;
    logic          carry;

    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b};
        carry    = 1'b0;
        unique case (op)
            AOP_PASS: pre = a;
            AOP_ADD: begin
                pre   = wide_sum[DW-1:0];
                carry = wide_sum[DW];
            end
            AOP_ADDR: pre = a & ADDR_MASK;
            AOP_AND:  pre = a & b;
            default:  pre = a;
        endcase

        unique case (sh)
            SH_RIGHT: res = {1'b0, pre[DW-1:1]};
            SH_LEFT:  res = {pre[DW-2:0], 1'b0};
            default:  res = pre;
        endcase

        fl.z = (res == '0);
        fl.n = res[DW-1];
        fl.c = carry;
    end

endmodule

// File: rtl/cpu3b_seq.sv
module cpu3b_seq
    import cpu3b_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] opcode,
    output uop_t          uop,
    output step_e         step,
    output logic          done
);

    typedef struct packed {
        step_e step;
        logic  done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = (st_q.step == ST_EX_W);
        if (st_q.step == ST_EX_W) begin
            st_d.step = ST_FETCH_A;
        end else begin
            st_d.step = step_e'(st_q.step + 4'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{step: ST_FETCH_A, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // control word decode for the current step
    always_comb begin
        uop = '0;
        unique case (st_q.step)
            ST_FETCH_A: begin
                uop.src_a = RS_PC;
                uop.op    = AOP_PASS;
                uop.exec  = 1'b1;
            end
            ST_FETCH_W: begin
                uop.wb  = 1'b1;
                uop.dst = RS_MAR;
            end
            ST_INC_A: begin
                uop.src_a  = RS_PC;
                uop.src_b  = RS_ONE;
                uop.use_b  = 1'b1;
                uop.op     = AOP_ADD;
                uop.exec   = 1'b1;
                uop.mem_rd = 1'b1;
            end
            ST_INC_W: begin
                uop.wb     = 1'b1;
                uop.dst    = RS_PC;
                uop.mbr_ld = 1'b1;
            end
            ST_IR_A: begin
                uop.src_a = RS_MBR;
                uop.op    = AOP_PASS;
                uop.exec  = 1'b1;
            end
            ST_IR_W: begin
                uop.wb  = 1'b1;
                uop.dst = RS_IR;
            end
            ST_OPA_A: begin
                uop.src_a = RS_IR;
                uop.op    = AOP_ADDR;
                uop.exec  = 1'b1;
            end
            ST_OPA_W: begin
                uop.wb  = 1'b1;
                uop.dst = RS_MAR;
            end
            ST_RD2: begin
                uop.mem_rd = 1'b1;
            end
            ST_LD2: begin
                uop.mbr_ld = 1'b1;
            end
            ST_EX_A: begin
                uop.src_a = RS_ACC;
                uop.src_b = RS_MBR;
                uop.use_b = 1'b1;
                uop.op    = AOP_ADD;
                uop.sh    = (opcode == OPC_ADD_SHR) ? SH_RIGHT : SH_NONE;
                uop.exec  = 1'b1;
            end
            ST_EX_W: begin
                uop.wb  = 1'b1;
                uop.dst = (opcode == OPC_FLAGS_ONLY) ? RS_ONE : RS_ACC;
            end
            default: uop = '0;
        endcase
    end

    assign step = st_q.step;
    assign done = st_q.done;

endmodule

// File: rtl/cpu3b_core.sv
module cpu3b_core
    import cpu3b_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int OW = OPC_W,
    parameter int N  = NREG,
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          instr_done,
    output logic [SW-1:0] step,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] ir_out,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_c
);

    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [DW-1:0] res;
        flags_t        fl;
    } dp_t;

    uop_t               uop;
    step_e              step_s;
    logic [N-1:0][DW-1:0] view;
    logic [DW-1:0]      a_bus, b_bus, rb_data, alu_res;
    flags_t             alu_fl;
    dp_t                dp_d, dp_q;

    cpu3b_seq #(.OW(OW)) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .opcode(view[RS_IR][DW-1:DW-OW]),
        .uop   (uop),
        .step  (step_s),
        .done  (instr_done)
    );

    cpu3b_regfile #(.DW(DW), .N(N)) i_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (IW'(uop.src_a)),
        .rb_idx (IW'(uop.src_b)),
        .ra_data(a_bus),
        .rb_data(rb_data),
        .wr_en  (uop.wb),
        .wr_idx (IW'(uop.dst)),
        .wr_data(dp_q.res),
        .mbr_ld (uop.mbr_ld),
        .mbr_din(mem_rdata),
        .view   (view)
    );

    assign b_bus = uop.use_b ? rb_data : '0;

    cpu3b_alu #(.DW(DW), .AW(AW)) i_alu (
        .a  (a_bus),
        .b  (b_bus),
        .op (uop.op),
        .sh (uop.sh),
        .res(alu_res),
        .fl (alu_fl)
    );

    // result register and condition codes
    always_comb begin
        dp_d = dp_q;
        if (uop.exec) begin
            dp_d.res = alu_res;
            dp_d.fl  = alu_fl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr = view[RS_MAR][AW-1:0];
    assign mem_rd   = uop.mem_rd;
    assign step     = SW'(step_s);
    assign pc_out   = view[RS_PC];
    assign acc_out  = view[RS_ACC];
    assign ir_out   = view[RS_IR];
    assign flag_z   = dp_q.fl.z;
    assign flag_n   = dp_q.fl.n;
    assign flag_c   = dp_q.fl.c;

endmodule

// File: rtl/cpu3b_checker.sv
module cpu3b_checker #(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] step,
    input logic          mem_rd,
    input logic          instr_done,
    input logic [DW-1:0] pc,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] ir,
    input logic [DW-1:0] b_bus
);

    // R1: the constant entry shows one on the B bus during the increment
    assert_one_on_bbus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 4'd2) |-> (b_bus == DW'(1)));

    // R3: the PC advances by exactly one over its write-back step
    assert_pc_plus_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 4'd3) |=> (pc == $past(pc) + DW'(1)));

    // R2: the flags-only write-back leaves the accumulator alone
    assert_flags_only_keeps_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 4'd11 && ir[DW-1:DW-4] == 4'h2) |=> (acc == $past(acc)));

    // R4: step stays in range and advances by one until it wraps
    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step <= 4'd11);
    assert_step_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step != 4'd11) |=> (step == $past(step) + 4'd1));
    assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 4'd11) |=> (step == 4'd0));

    // R5/R6: memory reads only in the two request steps
    assert_read_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (step == 4'd2 || step == 4'd8));

    // R10: completion is a single-clock pulse at the start of a new instruction
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);
    assert_done_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (step == 4'd0));

endmodule

bind cpu3b_core cpu3b_checker #(.DW(DW), .SW(SW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .mem_rd    (mem_rd),
    .instr_done(instr_done),
    .pc        (pc_out),
    .acc       (acc_out),
    .ir        (ir_out),
    .b_bus     (b_bus)
);

// File: tb/test_cpu3b_core.sv
module test_cpu3b_core;

    localparam int CLK_PERIOD = 10;
    localparam int N_INSTR    = 8;
    localparam int WATCHDOG   = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata = '0;
    logic        instr_done;
    logic [3:0]  step;
    logic [15:0] pc_out, acc_out, ir_out;
    logic        flag_z, flag_n, flag_c;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit started = 1'b0;
    int cyc = 0;

    logic [15:0] mem [4096];

    cpu3b_core i_cpu3b_core (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .instr_done(instr_done), .step(step),
        .pc_out(pc_out), .acc_out(acc_out), .ir_out(ir_out),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // synchronous memory: data one clock after the request
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model, stepped on every rising edge
    int          m_step;
    logic [15:0] m_pc, m_acc, m_ir, m_mar, m_mbr, m_res;
    logic [2:0]  m_fl;
    logic        m_done;

    function automatic logic [2:0] mk_fl(input logic [15:0] r, input logic c);
        return {r == 16'h0, r[15], c};
    endfunction

    always @(posedge clk) begin
        logic [16:0] s17;
        if (!rst_n) begin
            m_step = 0; m_pc = 0; m_acc = 0; m_ir = 0; m_mar = 0;
            m_mbr = 0; m_res = 0; m_fl = 0; m_done = 0;
        end else begin
            m_done = 1'b0;
            case (m_step)
                0: begin m_res = m_pc; m_fl = mk_fl(m_res, 1'b0); end
                1: m_mar = m_res;
                2: begin s17 = {1'b0, m_pc} + 17'd1; m_res = s17[15:0];
                         m_fl = mk_fl(m_res, s17[16]); end
                3: begin m_pc = m_res; m_mbr = mem[m_mar[11:0]]; end
                4: begin m_res = m_mbr; m_fl = mk_fl(m_res, 1'b0); end
                5: m_ir = m_res;
                6: begin m_res = {4'h0, m_ir[11:0]}; m_fl = mk_fl(m_res, 1'b0); end
                7: m_mar = m_res;
                8: ;
                9: m_mbr = mem[m_mar[11:0]];
                10: begin
                    s17 = {1'b0, m_acc} + {1'b0, m_mbr};
                    m_res = (m_ir[15:12] == 4'h3) ? {1'b0, s17[15:1]} : s17[15:0];
                    m_fl = mk_fl(m_res, s17[16]);
                end
                11: begin
                    if (m_ir[15:12] != 4'h2) m_acc = m_res;
                    m_done = 1'b1;
                end
                default: ;
            endcase
            m_step = (m_step == 11) ? 0 : m_step + 1;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && started && !finished) begin
            chk("R4", "step", 32'(step), 32'(m_step));
            chk("R10", "instr_done", 32'(instr_done), 32'(m_done));
            chk(m_step == 8 ? "R6" : "R5", "mem_rd", 32'(mem_rd), 32'(m_step == 2 || m_step == 8));
            chk(m_step == 8 ? "R6" : "R5", "mem_addr", 32'(mem_addr), 32'(m_mar[11:0]));
            chk("R3", "pc", 32'(pc_out), 32'(m_pc));
            chk("R7", "acc", 32'(acc_out), 32'(m_acc));
            chk("R5", "ir", 32'(ir_out), 32'(m_ir));
            chk("R9", "flags", 32'({flag_z, flag_n, flag_c}), 32'(m_fl));
        end
    end

    logic [15:0] exp_acc [N_INSTR];
    logic [2:0]  exp_fl  [N_INSTR];
    string       exp_req [N_INSTR];

    initial begin
        int last_done;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        // program: opcode in [15:12], operand address in [11:0]
        mem[0] = 16'h1100; mem[16'h100] = 16'h0005;
        mem[1] = 16'h1101; mem[16'h101] = 16'hFFFB;
        mem[2] = 16'h2102; mem[16'h102] = 16'h8000;
        mem[3] = 16'h1103; mem[16'h103] = 16'h7FFF;
        mem[4] = 16'h3104; mem[16'h104] = 16'h8003;
        mem[5] = 16'h1FFF; mem[16'hFFF] = 16'h1234;
        mem[6] = 16'h2105; mem[16'h105] = 16'hEDCB;
        mem[7] = 16'h0106; mem[16'h106] = 16'h0001;
        // expected results worked out by hand, flags as {Z,N,C}
        exp_acc[0] = 16'h0005; exp_fl[0] = 3'b000; exp_req[0] = "R7";
        exp_acc[1] = 16'h0000; exp_fl[1] = 3'b101; exp_req[1] = "R7";
        exp_acc[2] = 16'h0000; exp_fl[2] = 3'b010; exp_req[2] = "R2";
        exp_acc[3] = 16'h7FFF; exp_fl[3] = 3'b000; exp_req[3] = "R7";
        exp_acc[4] = 16'h0001; exp_fl[4] = 3'b001; exp_req[4] = "R8";
        exp_acc[5] = 16'h1235; exp_fl[5] = 3'b000; exp_req[5] = "R6";
        exp_acc[6] = 16'h1235; exp_fl[6] = 3'b101; exp_req[6] = "R2";
        exp_acc[7] = 16'h1236; exp_fl[7] = 3'b000; exp_req[7] = "R7";

        // R11: reset state
        repeat (2) @(negedge clk);
        chk("R11", "reset step", 32'(step), 0);
        chk("R11", "reset pc", 32'(pc_out), 0);
        chk("R11", "reset acc", 32'(acc_out), 0);
        chk("R11", "reset ir", 32'(ir_out), 0);
        chk("R11", "reset flags", 32'({flag_z, flag_n, flag_c}), 0);
        chk("R11", "reset done", 32'(instr_done), 0);
        chk("R11", "reset mem_rd", 32'(mem_rd), 0);
        rst_n = 1'b1;
        started = 1'b1;
        last_done = cyc;

        for (int k = 0; k < N_INSTR; k++) begin
            @(negedge clk);
            while (!instr_done) @(negedge clk);
            chk(exp_req[k], "acc after instruction", 32'(acc_out), 32'(exp_acc[k]));
            chk(exp_req[k] == "R7" ? "R9" : exp_req[k], "flags after instruction",
                32'({flag_z, flag_n, flag_c}), 32'(exp_fl[k]));
            // R1, R3: PC counts instructions even after writes aimed at the one entry
            chk(k >= 3 ? "R1" : "R3", "pc after instruction", 32'(pc_out), 32'(k + 1));
            chk("R5", "ir after instruction", 32'(ir_out), 32'(mem[k]));
            // R4: 12 clocks per instruction
            if (k > 0) chk("R4", "clocks per instruction", 32'(cyc - last_done), 12);
            last_done = cyc;
            // R10: pulse lasts one clock
            @(negedge clk);
            chk("R10", "done drops", 32'(instr_done), 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule